// File: doc/BRIEF.md
# Edge-Filtered Status Event Group

This block keeps one group of sixteen status flags for a measurement instrument. It samples a vector of live condition flags on every clock and compares each sample with the one taken a cycle earlier. Each bit has two transition masks. One lets a 0-to-1 change through and the other lets a 1-to-0 change through. A change that passes a mask sets a sticky event bit. The event bits stay set until the host reads them or a clear-status pulse arrives. An enable mask picks which event bits drive a single summary flag. A parent status byte collects that flag.

The design expects to be placed twice: once for the group of questionable-quality flags and once for the group of running-operation flags. Both copies are identical. Each bit means what the parent decides. The most significant bit is reserved. No register ever holds a one there, so every readback fits a signed 16-bit value.

A small host port reads the registers by address. It writes the two masks and the enable mask. Reading the event register also clears it.

Top module: `stat_evt_group`

## Requirements
- R1: If a condition bit goes from 0 to 1 and the matching rising-mask bit is 1, the matching event bit is set at the next clock edge.
- R2: If a condition bit goes from 1 to 0 and the matching falling-mask bit is 1, the matching event bit is set at the next clock edge.
- R3: After reset, the rising mask reads 0x7FFF. The falling mask, the enable mask, the event register and the condition register all read 0.
- R4: The condition register holds the input sampled at the previous clock edge. An edge is a difference between the present input and that stored sample. The stored sample starts at 0 after reset.
- R5: The host address selects a register: 0 condition, 1 rising mask, 2 falling mask, 3 event, 4 enable. Addresses 5 to 7 read 0. host_rdata shows the selected register in the same cycle. A write to address 1, 2 or 4 takes effect at the next edge. A write to address 0 or 3 is ignored.
- R6: summary is 1 exactly when some bit is set in both the event register and the enable mask, in the same cycle.
- R7: Bit 15 is never set in any register. Written ones and input ones in bit 15 are dropped.
- R8: host_rd at address 3 returns the current event value and clears the register at the next edge. An edge that passes a mask in that same cycle still leaves its bit set.
- R9: A clr_status pulse zeroes the event register at the next edge. The masks and the enable mask are left unchanged. An edge that passes a mask in that same cycle still leaves its bit set.
- R10: An event bit stays set until it is cleared through R8 or R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cond_in | input | 16 | Live condition flags |
| clr_status | input | 1 | Clear-status pulse for the event register |
| host_addr | input | 3 | Register select |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 16 | Write data |
| host_rd | input | 1 | Read strobe; clears the event register at address 3 |
| host_rdata | output | 16 | Selected register value |
| summary | output | 1 | OR of event bits that are enabled |

## Verification
Two things can land on the same clock edge: an event clear (from a read at address 3 or from clr_status) and a new filtered edge. The bench provokes this on purpose. It reads or pulses clr_status in the very cycle a condition bit toggles through an open mask. It then judges the next event readback: the old bits must be gone and the new bit must remain. A long random phase mixes toggling conditions, mask writes, reads and clears. That phase makes such collisions happen many more times, and every cycle is compared with the bench's behavioural model.

// File: rtl/stat_evt_pkg.sv
package stat_evt_pkg;
   localparam int unsigned SEL_W = 3;

   typedef enum logic [SEL_W-1:0] {
      SEL_COND = 3'd0,
      SEL_RISE = 3'd1,
      SEL_FALL = 3'd2,
      SEL_EVT  = 3'd3,
      SEL_ENA  = 3'd4
   } reg_sel_e;
endpackage

// File: rtl/stat_edge_filt.sv
module stat_edge_filt #(
   parameter int unsigned       WIDTH     = 16,
   parameter logic [WIDTH-1:0]  RSVD_MASK = {1'b1, {(WIDTH-1){1'b0}}}
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] cond_in,
   input  logic [WIDTH-1:0] rise_msk,
   input  logic [WIDTH-1:0] fall_msk,
   output logic [WIDTH-1:0] cond_q,
   output logic [WIDTH-1:0] hit
);
   logic [WIDTH-1:0] cond_s;

   assign cond_s = cond_in & ~RSVD_MASK;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cond_q <= '0;
      else        cond_q <= cond_s;
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      if (RSVD_MASK[b]) begin : g_rsvd
         assign hit[b] = 1'b0;
      end else begin : g_live
         logic up, dn;
         assign up     = cond_s[b] & ~cond_q[b];
         assign dn     = ~cond_s[b] & cond_q[b];
         assign hit[b] = (up & rise_msk[b]) | (dn & fall_msk[b]);
      end
   end

   // R4: the stored sample follows the masked input one edge later
   p_sample_r4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (cond_q == ($past(cond_in) & ~RSVD_MASK)));
endmodule

// File: rtl/stat_evt_store.sv
module stat_evt_store #(
   parameter int unsigned       WIDTH     = 16,
   parameter logic [WIDTH-1:0]  RSVD_MASK = {1'b1, {(WIDTH-1){1'b0}}}
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] hit,
   input  logic             clr,
   output logic [WIDTH-1:0] evt_q
);
   logic [WIDTH-1:0] base;

   assign base = clr ? '0 : evt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) evt_q <= '0;
      else        evt_q <= (base | hit) & ~RSVD_MASK;
   end

   // R1 and R2: a filtered edge always lands in the event register, even during a clear
   p_edge_latch_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (hit != '0) |=> ((evt_q & $past(hit)) == $past(hit)));
   // R10: without a clear, bits that are set stay set
   p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((evt_q & $past(evt_q)) == $past(evt_q)));
   // R8: a clear with no new edge empties the register
   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && (hit == '0)) |=> (evt_q == '0));
   // R7
   p_evt_rsvd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_q & RSVD_MASK) == '0);
endmodule

// File: rtl/stat_cfg_regs.sv
module stat_cfg_regs
   import stat_evt_pkg::*;
#(
   parameter int unsigned       WIDTH     = 16,
   parameter logic [WIDTH-1:0]  RSVD_MASK = {1'b1, {(WIDTH-1){1'b0}}}
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [SEL_W-1:0] addr,
   input  logic [WIDTH-1:0] wdata,
   output logic [WIDTH-1:0] rise_msk,
   output logic [WIDTH-1:0] fall_msk,
   output logic [WIDTH-1:0] ena_msk
);
   localparam logic [WIDTH-1:0] RISE_INIT = ~RSVD_MASK;
   localparam logic [WIDTH-1:0] FALL_INIT = '0;
   localparam logic [WIDTH-1:0] ENA_INIT  = '0;

   logic [WIDTH-1:0] wd_clean;
   assign wd_clean = wdata & ~RSVD_MASK;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rise_msk <= RISE_INIT;
         fall_msk <= FALL_INIT;
         ena_msk  <= ENA_INIT;
      end else if (wr) begin
         case (reg_sel_e'(addr))
            SEL_RISE: rise_msk <= wd_clean;
            SEL_FALL: fall_msk <= wd_clean;
            SEL_ENA:  ena_msk  <= wd_clean;
            default:  ;
         endcase
      end
   end

   // R7
   p_cfg_rsvd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((rise_msk | fall_msk | ena_msk) & RSVD_MASK) == '0);
   // R5: without a write the configuration holds
   p_cfg_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> ($stable(rise_msk) && $stable(fall_msk) && $stable(ena_msk)));
endmodule

// File: rtl/stat_evt_group.sv
module stat_evt_group
   import stat_evt_pkg::*;
#(
   parameter int unsigned       WIDTH       = 16,
   parameter logic [WIDTH-1:0]  RSVD_MASK   = {1'b1, {(WIDTH-1){1'b0}}},
   parameter bit                REG_SUMMARY = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] cond_in,
   input  logic             clr_status,
   input  logic [SEL_W-1:0] host_addr,
   input  logic             host_wr,
   input  logic [WIDTH-1:0] host_wdata,
   input  logic             host_rd,
   output logic [WIDTH-1:0] host_rdata,
   output logic             summary
);
   initial begin : elab_chk
      a_width: assert (WIDTH >= 2 && WIDTH <= 64)
         else $error("stat_evt_group: WIDTH out of range");
   end

   logic [WIDTH-1:0] rise_msk, fall_msk, ena_msk;
   logic [WIDTH-1:0] cond_q, hit, evt_q;
   logic             evt_clr;
   logic             sum_c;

   stat_cfg_regs #(.WIDTH(WIDTH), .RSVD_MASK(RSVD_MASK)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr(host_wr), .addr(host_addr),
      .wdata(host_wdata), .rise_msk(rise_msk), .fall_msk(fall_msk),
      .ena_msk(ena_msk)
   );

   stat_edge_filt #(.WIDTH(WIDTH), .RSVD_MASK(RSVD_MASK)) u_filt (
      .clk(clk), .rst_n(rst_n), .cond_in(cond_in), .rise_msk(rise_msk),
      .fall_msk(fall_msk), .cond_q(cond_q), .hit(hit)
   );

   assign evt_clr = clr_status | (host_rd & (reg_sel_e'(host_addr) == SEL_EVT));

   stat_evt_store #(.WIDTH(WIDTH), .RSVD_MASK(RSVD_MASK)) u_evt (
      .clk(clk), .rst_n(rst_n), .hit(hit), .clr(evt_clr), .evt_q(evt_q)
   );

   always_comb begin
      case (reg_sel_e'(host_addr))
         SEL_COND: host_rdata = cond_q;
         SEL_RISE: host_rdata = rise_msk;
         SEL_FALL: host_rdata = fall_msk;
         SEL_EVT:  host_rdata = evt_q;
         SEL_ENA:  host_rdata = ena_msk;
         default:  host_rdata = '0;
      endcase
   end

   assign sum_c = |(evt_q & ena_msk);

   if (REG_SUMMARY) begin : g_sum_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) summary <= 1'b0;
         else        summary <= |((((evt_clr ? '0 : evt_q) | hit) & ~RSVD_MASK) & ena_msk);
      end
   end else begin : g_sum_comb
      assign summary = sum_c;
   end

   // R9: a clear-status pulse never disturbs the configuration
   p_cls_keeps_cfg_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_status && !host_wr) |=> ($stable(rise_msk) && $stable(fall_msk) && $stable(ena_msk)));
   // R6: no enabled event means no summary
   p_sum_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ena_msk == '0) |-> (sum_c == 1'b0));
endmodule

// File: tb/stat_evt_group_tb.sv
module stat_evt_group_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cond_in = '0;
   logic        clr_status = 1'b0;
   logic [2:0]  host_addr = '0;
   logic        host_wr = 1'b0;
   logic [15:0] host_wdata = '0;
   logic        host_rd = 1'b0;
   logic [15:0] host_rdata;
   logic        summary;

   int checks = 0;
   int errors = 0;

   // reference state
   logic [15:0] m_cond, m_rise, m_fall, m_evt, m_ena;

   always #2 clk = ~clk;

   stat_evt_group dut_i (
      .clk(clk), .rst_n(rst_n), .cond_in(cond_in), .clr_status(clr_status),
      .host_addr(host_addr), .host_wr(host_wr), .host_wdata(host_wdata),
      .host_rd(host_rd), .host_rdata(host_rdata), .summary(summary)
   );

   task automatic model_reset();
      m_cond = 16'h0000; m_rise = 16'h7FFF; m_fall = 16'h0000;
      m_evt  = 16'h0000; m_ena  = 16'h0000;
   endtask

   function automatic logic [15:0] exp_rd(input logic [2:0] a);
      case (a)
         3'd0: return m_cond;
         3'd1: return m_rise;
         3'd2: return m_fall;
         3'd3: return m_evt;
         3'd4: return m_ena;
         default: return 16'h0000;
      endcase
   endfunction

   task automatic check(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // one clock: drive after the falling edge, compare before the rising edge, then advance the model
   task automatic step(input logic [2:0] a, input logic wr, input logic [15:0] wd,
                       input logic rd, input logic cls, input logic [15:0] c, input string tag);
      logic [15:0] cm;
      logic [15:0] nev;
      @(negedge clk);
      host_addr = a; host_wr = wr; host_wdata = wd; host_rd = rd;
      clr_status = cls; cond_in = c;
      #1;
      check(tag, "rdata", host_rdata, exp_rd(a));
      check("R6", "summary", {15'd0, summary}, {15'd0, ((m_evt & m_ena) != 0)});
      @(posedge clk);
      cm  = c;
      cm[15] = 1'b0;
      nev = (cls || (rd && a == 3'd3)) ? 16'h0000 : m_evt;
      for (int i = 0; i < 15; i++) begin
         if (!m_cond[i] && cm[i] && m_rise[i]) nev[i] = 1'b1;
         if (m_cond[i] && !cm[i] && m_fall[i]) nev[i] = 1'b1;
      end
      m_evt  = nev;
      m_cond = cm;
      if (wr) begin
         if (a == 3'd1) m_rise = wd & 16'h7FFF;
         if (a == 3'd2) m_fall = wd & 16'h7FFF;
         if (a == 3'd4) m_ena  = wd & 16'h7FFF;
      end
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin : watchdog
      #(200000 * 4);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin : main
      logic [15:0] c;
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      // R3: reset values of every register
      for (int a = 0; a < 8; a++) step(3'(a), 0, 0, 0, 0, 16'h0000, "R3");
      // R1: rising edge through the default rising mask
      step(3'd3, 0, 0, 0, 0, 16'h0008, "R1");
      step(3'd3, 0, 0, 0, 0, 16'h0008, "R1");
      check("R1", "evt bit3", m_evt, 16'h0008);
      // R4: condition register is the previous sample
      step(3'd0, 0, 0, 0, 0, 16'h0108, "R4");
      step(3'd0, 0, 0, 0, 0, 16'h0000, "R4");
      step(3'd0, 0, 0, 0, 0, 16'h0000, "R4");
      // R10: events persist after the condition returns low
      step(3'd3, 0, 0, 0, 0, 16'h0000, "R10");
      // R8: read clears
      step(3'd3, 0, 0, 1, 0, 16'h0000, "R8");
      step(3'd3, 0, 0, 0, 0, 16'h0000, "R8");
      // R2: falling mask only
      step(3'd1, 1, 16'h0000, 0, 0, 16'h0000, "R5");
      step(3'd2, 1, 16'h0020, 0, 0, 16'h0020, "R5");
      step(3'd3, 0, 0, 0, 0, 16'h0000, "R2");
      step(3'd3, 0, 0, 0, 0, 16'h0000, "R2");
      // R7: bit 15 dropped from writes and input
      step(3'd1, 1, 16'hFFFF, 0, 0, 16'hFFFF, "R7");
      step(3'd1, 0, 0, 0, 0, 16'hFFFF, "R7");
      step(3'd0, 0, 0, 0, 0, 16'hFFFF, "R7");
      // R5: writes to condition and event are ignored
      step(3'd0, 1, 16'h1234, 0, 0, 16'h0000, "R5");
      step(3'd3, 1, 16'h0000, 0, 0, 16'h0000, "R5");
      step(3'd0, 0, 0, 0, 0, 16'h0000, "R5");
      // R8: clearing read collides with a new edge
      step(3'd3, 0, 0, 1, 0, 16'h0001, "R8");
      step(3'd3, 0, 0, 0, 0, 16'h0001, "R8");
      // R6: enable drives summary
      step(3'd4, 1, 16'h0001, 0, 0, 16'h0001, "R6");
      step(3'd4, 0, 0, 0, 0, 16'h0001, "R6");
      step(3'd4, 1, 16'h0002, 0, 0, 16'h0001, "R6");
      step(3'd4, 1, 16'h0003, 0, 0, 16'h0001, "R6");
      // R9: clear-status with a colliding edge, configuration kept
      step(3'd3, 0, 0, 0, 1, 16'h0000, "R9");
      step(3'd3, 0, 0, 0, 0, 16'h0000, "R9");
      step(3'd1, 0, 0, 0, 1, 16'h0004, "R9");
      step(3'd2, 0, 0, 0, 0, 16'h0004, "R9");
      step(3'd4, 0, 0, 0, 0, 16'h0004, "R9");
      step(3'd3, 0, 0, 0, 0, 16'h0004, "R9");
      // R10: random mix of toggling conditions, writes, reads and clears
      c = 16'h0000;
      for (int n = 0; n < 3000; n++) begin
         logic [2:0] a;
         a = 3'($urandom_range(0, 7));
         c = c ^ 16'($urandom) & 16'($urandom);
         step(a, ($urandom_range(0, 7) == 0), 16'($urandom),
              ($urandom_range(0, 5) == 0), ($urandom_range(0, 15) == 0), c, "R10");
      end
      finish_run();
   end
endmodule